// File: doc/BRIEF.md
# Serial Audio Frame Timing Generator

This block produces the timing skeleton of a serial audio port. From a per-bit tick (or from a bit clock arriving from outside) it derives one launch strobe per bit, keeps a slot counter and a bit-in-slot counter, and drives a frame-sync line. A serializer that sits beside it uses the strobe, the counters, the data-bit index and the slot-active flag to know which bit of which channel word to shift next.

A single framing engine covers four framings. Each framing is a combination of three properties: whether the sync leads the first data bit by one bit, whether it lasts one whole slot or a single bit, and whether it is active low. The frame length is a programmable number of slots of programmable width, and the word inside a slot may be shorter than the slot. Bit order, per-slot muting and an active-channel count are also programmable. The polarity of the bit clock and of the frame sync can each be inverted, and each can be generated locally or taken from pins. When the sync comes from outside, the counters lock to it and any later sync edge at the wrong place is flagged.

All configuration inputs are expected to be changed only while `enable_i` is low.

Top module: `tdm_fg_gen`

## Requirements
- R1: While `enable_i` is low, the counters sit on the last bit of the last slot (`slot_idx_o` = effective slots - 1, `bit_idx_o` = slot width - 1). `fs_o` holds its inactive level (high for mode 0, low otherwise, flipped by `fs_inv_i`). `step_o`, `frame_end_o` and `sync_err_o` stay low.
- R2: With `bclk_gen_i` = 1, `bclk_o` toggles once for each clock cycle in which `bit_tick_i` is high; it starts low, before inversion. The counters advance on the tick that takes the uninverted bit clock from high to low, and `step_o` is high for the one cycle in which the new position is first shown.
- R3: With `bclk_gen_i` = 0, `ext_bclk_i` passes through a two-stage synchronizer. A falling edge of `ext_bclk_i` XOR `bclk_inv_i` advances the counters once, with `step_o` marking the update as in R2.
- R4: The bit position counts 0 to slot width - 1. After the last bit the slot index increments, and after the last slot it wraps to 0. A programmed slot count below 2 behaves as 2 slots.
- R5: Mode 0 (slot-wide, early, active low): `fs_o` is active on the last bit of the previous frame and on bits 0 to width - 2 of slot 0.
- R6: Mode 1 (slot-wide, active high): `fs_o` is active for all bits of slot 0.
- R7: Mode 2 (one bit, early, active high): `fs_o` is active only on the last bit of the last slot, one bit before the first data bit.
- R8: Mode 3 (one bit, active high): `fs_o` is active only on bit 0 of slot 0.
- R9: `fs_inv_i` = 1 inverts `fs_o` in every mode. `bclk_inv_i` = 1 inverts `bclk_o` and makes the rising edge of `ext_bclk_i` the launch edge.
- R10: `data_bit_o` is `bit_idx_o` when `lsb_first_i` = 1, and word width - 1 - `bit_idx_o` otherwise. `data_valid_o` is high only while enabled, in an active slot, with `bit_idx_o` below `word_width_i`.
- R11: `slot_active_o` is low when `slot_mask_i[slot_idx_o]` is 1 or when `slot_idx_o` is not below `channels_i`.
- R12: `frame_end_o` is a one-cycle pulse, together with `step_o`, in the cycle the counters first show the last bit of the last slot.
- R13: With `fs_gen_i` = 0, an inactive-to-active edge of the synchronized external sync (normalized by mode and `fs_inv_i`) seen at a launch moves the counters to the framing's start position: the last bit of the last slot for modes 0 and 2, and bit 0 of slot 0 otherwise. The first such edge after enable aligns without complaint. Any later edge that lands anywhere but the expected position raises `sync_err_o` for one cycle, together with `step_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the frame engine |
| mode_i | input | 2 | Framing: 0 slot-wide early active-low, 1 slot-wide, 2 one-bit early, 3 one-bit |
| bclk_gen_i | input | 1 | 1: bit clock from `bit_tick_i`, 0: from `ext_bclk_i` |
| fs_gen_i | input | 1 | 1: frame sync generated, 0: locked to `ext_fs_i` |
| bclk_inv_i | input | 1 | Invert bit clock polarity |
| fs_inv_i | input | 1 | Invert frame sync polarity |
| lsb_first_i | input | 1 | Bit order of the data word |
| num_slots_i | input | 4 | Slots per frame (values below 2 act as 2) |
| slot_width_i | input | 6 | Bits per slot |
| word_width_i | input | 6 | Data bits per word |
| channels_i | input | 4 | Number of active channel slots |
| slot_mask_i | input | 8 | Per-slot mute, 1 = inactive |
| bit_tick_i | input | 1 | Half-bit tick from a divider |
| ext_bclk_i | input | 1 | External bit clock |
| ext_fs_i | input | 1 | External frame sync |
| bclk_o | output | 1 | Generated bit clock |
| fs_o | output | 1 | Frame sync |
| step_o | output | 1 | New bit position strobe |
| slot_idx_o | output | 3 | Current slot |
| bit_idx_o | output | 5 | Bit position within the slot |
| data_bit_o | output | 5 | Data word bit number for this position |
| data_valid_o | output | 1 | This position carries a data bit |
| slot_active_o | output | 1 | Current slot is not muted |
| frame_end_o | output | 1 | Last bit of frame reached |
| sync_err_o | output | 1 | External sync at unexpected position |

## Verification
The assertions take for granted that the slot count, the slot width (at least 1), the word width and the polarities are changed only while the engine is disabled. They also assume the slot count does not exceed the counter range and that `bit_tick_i` pulses only while the bit clock is generated. The stimulus sets every configuration with the engine off and only then enables it. It spaces bit ticks and external clock edges several system clocks apart, so the synchronizers see clean levels. It changes the external sync only together with the external launch edge.

// File: rtl/tdm_fg_pkg.sv
package tdm_fg_pkg;

  typedef enum logic [1:0] {
    FMT_WORD_EARLY_LOW = 2'd0,
    FMT_WORD_ALIGNED   = 2'd1,
    FMT_BIT_EARLY      = 2'd2,
    FMT_BIT_ALIGNED    = 2'd3
  } fmt_e;

  // sync leads the first data bit by one bit clock
  function automatic logic fmt_early(input logic [1:0] m);
    return (m == FMT_WORD_EARLY_LOW) || (m == FMT_BIT_EARLY);
  endfunction

  // sync lasts a whole slot rather than one bit
  function automatic logic fmt_wide(input logic [1:0] m);
    return (m == FMT_WORD_EARLY_LOW) || (m == FMT_WORD_ALIGNED);
  endfunction

  function automatic logic fmt_low(input logic [1:0] m);
    return (m == FMT_WORD_EARLY_LOW);
  endfunction

endpackage

// File: rtl/tdm_fg_edge.sv
module tdm_fg_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic gen_i,
  input  logic inv_i,
  input  logic tick_i,
  input  logic ext_bclk_i,
  input  logic ext_fs_i,
  output logic phase_o,
  output logic step_o,
  output logic fs_smp_o
);

  logic       phase_q, phase_d;
  logic [2:0] bs_q, bs_d;
  logic [1:0] fs_q, fs_d;
  logic       norm_now, norm_prev;

  always_comb begin
    phase_d = phase_q;
    if (!en_i || !gen_i) begin
      phase_d = 1'b0;
    end else if (tick_i) begin
      phase_d = ~phase_q;
    end
    bs_d = {bs_q[1:0], ext_bclk_i};
    fs_d = {fs_q[0], ext_fs_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      bs_q    <= 3'b000;
      fs_q    <= 2'b00;
    end else begin
      phase_q <= phase_d;
      bs_q    <= bs_d;
      fs_q    <= fs_d;
    end
  end

  assign norm_now  = bs_q[1] ^ inv_i;
  assign norm_prev = bs_q[2] ^ inv_i;

  assign step_o   = en_i && (gen_i ? (tick_i && phase_q) : (norm_prev && !norm_now));
  assign phase_o  = phase_q;
  assign fs_smp_o = fs_q[1];

endmodule

// File: rtl/tdm_fg_count.sv
module tdm_fg_count #(
  parameter int SLOT_W = 3,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  input  logic [POS_W-1:0]  last_pos_i,
  input  logic [SLOT_W-1:0] tgt_slot_i,
  input  logic [POS_W-1:0]  tgt_pos_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [SLOT_W-1:0] adv_slot_o,
  output logic [POS_W-1:0]  adv_pos_o,
  output logic [SLOT_W-1:0] nxt_slot_o,
  output logic [POS_W-1:0]  nxt_pos_o
);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [POS_W-1:0]  pos_q, pos_d;

  always_comb begin
    if (pos_q >= last_pos_i) begin
      adv_pos_o  = '0;
      adv_slot_o = (slot_q >= last_slot_i) ? '0 : slot_q + 1'b1;
    end else begin
      adv_pos_o  = pos_q + 1'b1;
      adv_slot_o = slot_q;
    end
    nxt_slot_o = load_i ? tgt_slot_i : adv_slot_o;
    nxt_pos_o  = load_i ? tgt_pos_i  : adv_pos_o;

    slot_d = slot_q;
    pos_d  = pos_q;
    if (!en_i) begin
      slot_d = last_slot_i;
      pos_d  = last_pos_i;
    end else if (step_i) begin
      slot_d = nxt_slot_o;
      pos_d  = nxt_pos_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      pos_q  <= '0;
    end else begin
      slot_q <= slot_d;
      pos_q  <= pos_d;
    end
  end

  assign slot_o = slot_q;
  assign pos_o  = pos_q;

endmodule

// File: rtl/tdm_fg_frame.sv
module tdm_fg_frame
  import tdm_fg_pkg::*;
#(
  parameter int SLOT_W = 3,
  parameter int POS_W  = 5
) (
  input  logic [1:0]        mode_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic [SLOT_W-1:0] last_slot_i,
  input  logic [POS_W-1:0]  last_pos_i,
  output logic              active_o,
  output logic              low_o,
  output logic [SLOT_W-1:0] tgt_slot_o,
  output logic [POS_W-1:0]  tgt_pos_o
);

  logic              early, wide;
  logic [SLOT_W-1:0] look_slot;
  logic [POS_W-1:0]  look_pos;

  always_comb begin
    early = fmt_early(mode_i);
    wide  = fmt_wide(mode_i);
    low_o = fmt_low(mode_i);

    // an early framing sees the position one bit ahead
    look_slot = slot_i;
    look_pos  = pos_i;
    if (early) begin
      if (pos_i >= last_pos_i) begin
        look_pos  = '0;
        look_slot = (slot_i >= last_slot_i) ? '0 : slot_i + 1'b1;
      end else begin
        look_pos  = pos_i + 1'b1;
      end
    end

    active_o = wide ? (look_slot == '0) : ((look_slot == '0) && (look_pos == '0));

    tgt_slot_o = early ? last_slot_i : '0;
    tgt_pos_o  = early ? last_pos_i  : '0;
  end

endmodule

// File: rtl/tdm_fg_gen.sv
module tdm_fg_gen #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WIDTH = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int CNT_W  = SLOT_W + 1,
  localparam int POS_W  = $clog2(MAX_WIDTH),
  localparam int WID_W  = POS_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable_i,
  input  logic [1:0]           mode_i,
  input  logic                 bclk_gen_i,
  input  logic                 fs_gen_i,
  input  logic                 bclk_inv_i,
  input  logic                 fs_inv_i,
  input  logic                 lsb_first_i,
  input  logic [CNT_W-1:0]     num_slots_i,
  input  logic [WID_W-1:0]     slot_width_i,
  input  logic [WID_W-1:0]     word_width_i,
  input  logic [CNT_W-1:0]     channels_i,
  input  logic [MAX_SLOTS-1:0] slot_mask_i,
  input  logic                 bit_tick_i,
  input  logic                 ext_bclk_i,
  input  logic                 ext_fs_i,
  output logic                 bclk_o,
  output logic                 fs_o,
  output logic                 step_o,
  output logic [SLOT_W-1:0]    slot_idx_o,
  output logic [POS_W-1:0]     bit_idx_o,
  output logic [POS_W-1:0]     data_bit_o,
  output logic                 data_valid_o,
  output logic                 slot_active_o,
  output logic                 frame_end_o,
  output logic                 sync_err_o
);

  logic [CNT_W-1:0]  eff_slots;
  logic [SLOT_W-1:0] last_slot;
  logic [POS_W-1:0]  last_pos;
  logic              phase, step, fs_smp;
  logic              active, low;
  logic [SLOT_W-1:0] tgt_slot, adv_slot, nxt_slot, slot_q;
  logic [POS_W-1:0]  tgt_pos, adv_pos, nxt_pos, pos_q;
  logic              fs_norm, fs_edge, mis_place;

  logic step_q, step_d;
  logic fend_q, fend_d;
  logic err_q, err_d;
  logic fsp_q, fsp_d;
  logic lock_q, lock_d;

  assign eff_slots = (num_slots_i < CNT_W'(2)) ? CNT_W'(2) : num_slots_i;
  assign last_slot = SLOT_W'(eff_slots - CNT_W'(1));
  assign last_pos  = POS_W'(slot_width_i - WID_W'(1));

  tdm_fg_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (enable_i),
    .gen_i     (bclk_gen_i),
    .inv_i     (bclk_inv_i),
    .tick_i    (bit_tick_i),
    .ext_bclk_i(ext_bclk_i),
    .ext_fs_i  (ext_fs_i),
    .phase_o   (phase),
    .step_o    (step),
    .fs_smp_o  (fs_smp)
  );

  tdm_fg_frame #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_frame (
    .mode_i     (mode_i),
    .slot_i     (slot_q),
    .pos_i      (pos_q),
    .last_slot_i(last_slot),
    .last_pos_i (last_pos),
    .active_o   (active),
    .low_o      (low),
    .tgt_slot_o (tgt_slot),
    .tgt_pos_o  (tgt_pos)
  );

  tdm_fg_count #(.SLOT_W(SLOT_W), .POS_W(POS_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (enable_i),
    .step_i     (step),
    .load_i     (fs_edge),
    .last_slot_i(last_slot),
    .last_pos_i (last_pos),
    .tgt_slot_i (tgt_slot),
    .tgt_pos_i  (tgt_pos),
    .slot_o     (slot_q),
    .pos_o      (pos_q),
    .adv_slot_o (adv_slot),
    .adv_pos_o  (adv_pos),
    .nxt_slot_o (nxt_slot),
    .nxt_pos_o  (nxt_pos)
  );

  // external sync, normalized so that 1 means asserted
  assign fs_norm   = fs_smp ^ low ^ fs_inv_i;
  assign fs_edge   = !fs_gen_i && step && fs_norm && !fsp_q;
  assign mis_place = (adv_slot != tgt_slot) || (adv_pos != tgt_pos);

  always_comb begin
    step_d = step;
    fend_d = step && (nxt_slot == last_slot) && (nxt_pos == last_pos);
    err_d  = fs_edge && lock_q && mis_place;
    fsp_d  = fsp_q;
    lock_d = lock_q;
    if (!enable_i) begin
      fsp_d  = 1'b0;
      lock_d = 1'b0;
    end else begin
      if (step)    fsp_d  = fs_norm;
      if (fs_edge) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 1'b0;
      fend_q <= 1'b0;
      err_q  <= 1'b0;
      fsp_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      step_q <= step_d;
      fend_q <= fend_d;
      err_q  <= err_d;
      fsp_q  <= fsp_d;
      lock_q <= lock_d;
    end
  end

  assign bclk_o        = phase ^ bclk_inv_i;
  assign fs_o          = (enable_i && active) ^ low ^ fs_inv_i;
  assign step_o        = step_q;
  assign frame_end_o   = fend_q;
  assign sync_err_o    = err_q;
  assign slot_idx_o    = slot_q;
  assign bit_idx_o     = pos_q;
  assign slot_active_o = !slot_mask_i[slot_q] && ({1'b0, slot_q} < channels_i);
  assign data_valid_o  = enable_i && slot_active_o && ({1'b0, pos_q} < word_width_i);
  assign data_bit_o    = lsb_first_i ? pos_q
                                     : POS_W'(word_width_i - WID_W'(1) - {1'b0, pos_q});

endmodule

// File: rtl/tdm_fg_chk.sv
module tdm_fg_chk #(
  parameter int MAX_SLOTS = 8,
  parameter int MAX_WIDTH = 32,
  localparam int SLOT_W = $clog2(MAX_SLOTS),
  localparam int CNT_W  = SLOT_W + 1,
  localparam int POS_W  = $clog2(MAX_WIDTH),
  localparam int WID_W  = POS_W + 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable_i,
  input logic [1:0]           mode_i,
  input logic                 bclk_gen_i,
  input logic                 fs_gen_i,
  input logic                 fs_inv_i,
  input logic [CNT_W-1:0]     num_slots_i,
  input logic [WID_W-1:0]     slot_width_i,
  input logic [WID_W-1:0]     word_width_i,
  input logic [MAX_SLOTS-1:0] slot_mask_i,
  input logic                 bit_tick_i,
  input logic                 bclk_o,
  input logic                 fs_o,
  input logic                 step_o,
  input logic [SLOT_W-1:0]    slot_idx_o,
  input logic [POS_W-1:0]     bit_idx_o,
  input logic                 data_valid_o,
  input logic                 slot_active_o,
  input logic                 frame_end_o,
  input logic                 sync_err_o
);

  logic [CNT_W-1:0] top_slot;
  assign top_slot = (num_slots_i < CNT_W'(2)) ? CNT_W'(1) : num_slots_i - CNT_W'(1);

  // R1: idle sync level and no strobes after a disabled cycle
  p_idle_fs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |-> (fs_o == (fs_inv_i ^ (mode_i == 2'd0))));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable_i) |-> (!step_o && !frame_end_o && !sync_err_o));

  // R2: counters move only with a strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && $past(enable_i) && !step_o) |-> ($stable(slot_idx_o) && $stable(bit_idx_o)));

  // R2: generated clock changes only after a tick
  p_bclk_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && $past(enable_i) && bclk_gen_i && $past(bclk_gen_i) && $past(!bit_tick_i))
      |-> $stable(bclk_o));

  // R4: counters stay inside the programmed frame
  p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable_i |-> (({1'b0, slot_idx_o} <= top_slot) && ({1'b0, bit_idx_o} < slot_width_i)));

  // R10: valid data only in an active slot inside the word
  p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (slot_active_o && ({1'b0, bit_idx_o} < word_width_i)));

  // R11: a masked slot is never active
  p_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    slot_mask_i[slot_idx_o] |-> !slot_active_o);

  // R12: frame end marks the last bit of the last slot
  p_fend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |-> (step_o && ({1'b0, slot_idx_o} == top_slot)
                     && ({1'b0, bit_idx_o} == slot_width_i - WID_W'(1))));

  // R13: sync errors only with an external sync, on a strobe
  p_err_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |-> (!fs_gen_i && step_o));

endmodule

bind tdm_fg_gen tdm_fg_chk #(.MAX_SLOTS(MAX_SLOTS), .MAX_WIDTH(MAX_WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable_i     (enable_i),
  .mode_i       (mode_i),
  .bclk_gen_i   (bclk_gen_i),
  .fs_gen_i     (fs_gen_i),
  .fs_inv_i     (fs_inv_i),
  .num_slots_i  (num_slots_i),
  .slot_width_i (slot_width_i),
  .word_width_i (word_width_i),
  .slot_mask_i  (slot_mask_i),
  .bit_tick_i   (bit_tick_i),
  .bclk_o       (bclk_o),
  .fs_o         (fs_o),
  .step_o       (step_o),
  .slot_idx_o   (slot_idx_o),
  .bit_idx_o    (bit_idx_o),
  .data_valid_o (data_valid_o),
  .slot_active_o(slot_active_o),
  .frame_end_o  (frame_end_o),
  .sync_err_o   (sync_err_o)
);

// File: tb/tdm_fg_gen_test.sv
module tdm_fg_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable_i, bclk_gen_i, fs_gen_i, bclk_inv_i, fs_inv_i, lsb_first_i;
  logic [1:0] mode_i;
  logic [3:0] num_slots_i, channels_i;
  logic [5:0] slot_width_i, word_width_i;
  logic [7:0] slot_mask_i;
  logic       bit_tick_i, ext_bclk_i, ext_fs_i;
  logic       bclk_o, fs_o, step_o, data_valid_o, slot_active_o, frame_end_o, sync_err_o;
  logic [2:0] slot_idx_o;
  logic [4:0] bit_idx_o, data_bit_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_fg_gen uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .mode_i(mode_i),
    .bclk_gen_i(bclk_gen_i), .fs_gen_i(fs_gen_i), .bclk_inv_i(bclk_inv_i),
    .fs_inv_i(fs_inv_i), .lsb_first_i(lsb_first_i), .num_slots_i(num_slots_i),
    .slot_width_i(slot_width_i), .word_width_i(word_width_i), .channels_i(channels_i),
    .slot_mask_i(slot_mask_i), .bit_tick_i(bit_tick_i), .ext_bclk_i(ext_bclk_i),
    .ext_fs_i(ext_fs_i), .bclk_o(bclk_o), .fs_o(fs_o), .step_o(step_o),
    .slot_idx_o(slot_idx_o), .bit_idx_o(bit_idx_o), .data_bit_o(data_bit_o),
    .data_valid_o(data_valid_o), .slot_active_o(slot_active_o),
    .frame_end_o(frame_end_o), .sync_err_o(sync_err_o)
  );

  typedef struct {
    int slot; int pos; int fs; int fend; int serr; int act; int dval; int dbit;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;

  // bench model state
  int e_f;
  bit m_prev, m_locked;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int n_slots();
    return (int'(num_slots_i) < 2) ? 2 : int'(num_slots_i);
  endfunction

  function automatic bit is_early();
    return (mode_i == 2'd0) || (mode_i == 2'd2);
  endfunction

  function automatic bit low_act();
    return (mode_i == 2'd0);
  endfunction

  function automatic bit model_active(input int f);
    int n, w, g;
    n = n_slots() * int'(slot_width_i);
    w = int'(slot_width_i);
    g = is_early() ? (f + 1) % n : f;
    if ((mode_i == 2'd0) || (mode_i == 2'd1)) return g < w;
    return g == 0;
  endfunction

  task automatic push_exp(input string tag, input bit serr);
    exp_t x;
    int w, ww;
    w  = int'(slot_width_i);
    ww = int'(word_width_i);
    x.slot = e_f / w;
    x.pos  = e_f % w;
    x.fs   = int'(model_active(e_f) ^ low_act() ^ fs_inv_i);
    x.fend = int'(e_f == n_slots() * w - 1);
    x.serr = int'(serr);
    x.act  = int'(!slot_mask_i[x.slot] && (x.slot < int'(channels_i)));
    x.dval = int'((x.act != 0) && (x.pos < ww));
    x.dbit = lsb_first_i ? x.pos : (ww - 1 - x.pos);
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  task automatic tick();
    @(posedge clk); #1 bit_tick_i = 1'b1;
    @(posedge clk); #1 bit_tick_i = 1'b0;
  endtask

  // driver: predicts one bit position, then produces the launch edge
  task automatic bit_step(input string tag, input bit fs_act);
    int n, adv, tgt;
    bit edge_seen, serr;
    n   = n_slots() * int'(slot_width_i);
    adv = (e_f + 1) % n;
    tgt = is_early() ? n - 1 : 0;
    edge_seen = !fs_gen_i && fs_act && !m_prev;
    m_prev = fs_act;
    serr = edge_seen && m_locked && (adv != tgt);
    e_f  = edge_seen ? tgt : adv;
    if (edge_seen) m_locked = 1'b1;
    push_exp(tag, serr);
    if (bclk_gen_i) begin
      tick();
      @(negedge clk);
      chk("R2", "bclk_o after rising tick", int'(bclk_o), int'(1'b1 ^ bclk_inv_i));
      tick();
      @(negedge clk);
      chk("R2", "bclk_o after falling tick", int'(bclk_o), int'(bclk_inv_i));
      repeat (2) @(posedge clk);
    end else begin
      @(posedge clk); #1 ext_bclk_i = 1'b1 ^ bclk_inv_i;
      repeat (4) @(posedge clk);
      #1 ext_bclk_i = bclk_inv_i;
      ext_fs_i = fs_act ^ low_act() ^ fs_inv_i;
      repeat (5) @(posedge clk);
    end
  endtask

  task automatic start_run(input logic [1:0] md, input int ns, input int sw, input int ww,
                           input int ch, input logic [7:0] mask, input bit lsb,
                           input bit bgen, input bit fgen, input bit binv, input bit finv);
    @(posedge clk); #1 enable_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    mode_i = md; num_slots_i = 4'(ns); slot_width_i = 6'(sw); word_width_i = 6'(ww);
    channels_i = 4'(ch); slot_mask_i = mask; lsb_first_i = lsb;
    bclk_gen_i = bgen; fs_gen_i = fgen; bclk_inv_i = binv; fs_inv_i = finv;
    ext_bclk_i = binv;
    ext_fs_i   = low_act() ^ finv;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "idle fs_o", int'(fs_o), int'(low_act() ^ finv));
    chk("R1", "idle slot_idx_o", int'(slot_idx_o), n_slots() - 1);
    chk("R1", "idle bit_idx_o", int'(bit_idx_o), sw - 1);
    chk("R1", "idle step_o", int'(step_o), 0);
    e_f = n_slots() * sw - 1;
    m_prev = 1'b0;
    m_locked = 1'b0;
    @(posedge clk); #1 enable_i = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  // monitor: compares every new position against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      if (step_o) begin
        if (exp_q.size() == 0) begin
          chk("R2", "unexpected step_o", 1, 0);
        end else begin
          exp_t  x;
          string t;
          x = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, "slot_idx_o", int'(slot_idx_o), x.slot);
          chk(t, "bit_idx_o", int'(bit_idx_o), x.pos);
          chk(t, "fs_o", int'(fs_o), x.fs);
          chk({t, "/R12"}, "frame_end_o", int'(frame_end_o), x.fend);
          chk({t, "/R13"}, "sync_err_o", int'(sync_err_o), x.serr);
          chk({t, "/R11"}, "slot_active_o", int'(slot_active_o), x.act);
          chk({t, "/R10"}, "data_valid_o", int'(data_valid_o), x.dval);
          if (x.dval != 0) chk({t, "/R10"}, "data_bit_o", int'(data_bit_o), x.dbit);
        end
      end else if (frame_end_o || sync_err_o) begin
        chk("R12", "strobe without step_o", 1, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable_i = 1'b0; mode_i = 2'd0; bclk_gen_i = 1'b1; fs_gen_i = 1'b1;
    bclk_inv_i = 1'b0; fs_inv_i = 1'b0; lsb_first_i = 1'b0; num_slots_i = 4'd2;
    slot_width_i = 6'd4; word_width_i = 6'd4; channels_i = 4'd2; slot_mask_i = 8'h00;
    bit_tick_i = 1'b0; ext_bclk_i = 1'b0; ext_fs_i = 1'b0;
    e_f = 0; m_prev = 1'b0; m_locked = 1'b0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: state after reset
    chk("R1", "reset fs_o", int'(fs_o), 1);
    chk("R1", "reset step_o", int'(step_o), 0);
    chk("R1", "reset slot_idx_o", int'(slot_idx_o), 1);
    chk("R1", "reset bit_idx_o", int'(bit_idx_o), 3);
    chk("R2", "reset bclk_o", int'(bclk_o), 0);

    // R5 with R4: early active-low word sync, two frames
    start_run(2'd0, 2, 4, 4, 2, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) bit_step("R4/R5", 1'b0);

    // R6 with R4: one programmed slot acts as two, LSB first, one channel
    start_run(2'd1, 1, 3, 3, 1, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 12; k++) bit_step("R4/R6", 1'b0);

    // R7 with R9: early one-bit sync, sync inverted, slot 2 masked
    start_run(2'd2, 4, 2, 2, 4, 8'h04, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    for (int k = 0; k < 16; k++) bit_step("R7/R9", 1'b0);

    // R8: aligned one-bit sync, word shorter than slot
    start_run(2'd3, 3, 4, 3, 3, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 24; k++) bit_step("R8", 1'b0);

    // R3 with R9: external inverted bit clock
    start_run(2'd0, 2, 3, 3, 2, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 12; k++) bit_step("R3/R9", 1'b0);

    // R13: external sync, silent lock, good edge, then one misplaced edge
    start_run(2'd3, 2, 4, 4, 2, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 24; k++) bit_step("R13", (k == 3) || (k == 11) || (k == 14) || (k == 22));

    @(posedge clk); #1 enable_i = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1", "fs_o after disable", int'(fs_o), 0);
    chk("R2", "expected queue drained", exp_q.size(), 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule